// File: doc/BRIEF.md
# Byte-Stream Register Access Bridge

The bridge sits between a host byte channel and a single-master register bus. The host sends short commands as a sequence of bytes on a valid/ready input stream. The bridge decodes each command and makes at most one single-beat access on the register bus. It then sends its answer back as bytes on a valid/ready output stream. Three commands exist: a capability query that describes what the bridge supports, an 8-bit register read, and an 8-bit register write.

Each command begins with an opcode byte. Read and write commands continue with the register address, sent as whole bytes with the most significant byte first. The number of address bytes comes from rounding the bus address width `ADDR_W` (1 to 16) up to a multiple of eight. A write then carries one data byte. The bridge handles one command at a time. It holds its input ready low from the moment it starts a register access until the last byte of the answer has been taken. This lets a host push bytes freely without losing any of them.

Top module: `csrb_bridge`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid`, `csr_re` and `csr_we` are all 0.
- R2: Opcode 0x00 returns four bytes, in this order. First is a flag byte: bit0 is 8-bit access supported (1); bits 1, 2 and 3 are 16-, 32- and 64-bit access (0); bit4 is non-incrementing burst (0); bit5 is incrementing burst (0); bit6 is address-less access (0); bit7 is 0. So the flag byte is 0x01. Then come a burst width of 0x00, the value of `ADDR_W`, and a data width of 0x08.
- R3: The address follows the opcode as ceil(ADDR_W/8) bytes, most significant byte first. Bits above `ADDR_W` are dropped, and the remaining bits appear on `csr_addr`.
- R4: Opcode 0x01 makes exactly one `csr_re` pulse at the received address. `csr_rdata` is sampled in the cycle after that pulse. Exactly one output byte is produced, carrying that value, and it becomes valid two cycles after the pulse.
- R5: Opcode 0x02 is followed by the address and then one data byte. It makes exactly one `csr_we` pulse carrying that address and data. In the next cycle, a single 0x00 acknowledge byte becomes valid on the output.
- R6: `in_ready` is 0 while a register access is being made or any response byte is still unsent, so no input byte is lost.
- R7: Any opcode other than 0x00, 0x01 or 0x02 is discarded. It makes no bus access and no output, and the next byte is taken as a new opcode.
- R8: Results are correct with 0 to 2 idle cycles between input bytes and 0 to 2 stall cycles before each output byte is taken. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold steady.
- R9: `csr_re` and `csr_we` are never 1 in the same cycle, and each access strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte offered |
| in_ready | output | 1 | Bridge accepts the offered byte |
| in_data | input | 8 | Command byte |
| out_valid | output | 1 | Response byte offered |
| out_ready | input | 1 | Host takes the response byte |
| out_data | output | 8 | Response byte |
| csr_addr | output | ADDR_W | Register address |
| csr_re | output | 1 | One-cycle read strobe |
| csr_we | output | 1 | One-cycle write strobe |
| csr_wdata | output | 8 | Write data |
| csr_rdata | input | 8 | Read data, valid the cycle after `csr_re` |

## Verification
Each bus strobe appears in the cycle after the last command byte is accepted. A read answer is valid two cycles after its `csr_re` pulse, and the write acknowledge is valid one cycle after `csr_we`. The checker pins down these delays exactly. The bench drives a byte at a falling edge and holds it until the handshake edge. It waits for `out_valid` at falling edges and latches `out_data` before the accepting edge, so its checks do not depend on the gap and stall pattern. After each command, the bench checks the bus-strobe counts and waits a few cycles to confirm that no extra output byte follows.

// File: rtl/csrb_pkg.sv
package csrb_pkg;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_ACCESS,
        ST_CAPTURE,
        ST_DRAIN
    } cmd_state_e;

    localparam logic [7:0] OP_CAPS   = 8'h00;
    localparam logic [7:0] OP_READ   = 8'h01;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] WRITE_ACK = 8'h00;

    localparam int CAP_BYTES = 4;
    localparam int DATA_W    = 8;

    // flag bit positions in capability byte 0
    localparam int CAPF_ACC8    = 0;
    localparam int CAPF_ACC16   = 1;
    localparam int CAPF_ACC32   = 2;
    localparam int CAPF_ACC64   = 3;
    localparam int CAPF_BNONINC = 4;
    localparam int CAPF_BINC    = 5;
    localparam int CAPF_NOADDR  = 6;

    function automatic logic [7:0] cap_byte(input int idx, input int aw);
        logic [7:0] flags;
        flags = '0;
        flags[CAPF_ACC8]    = 1'b1;
        flags[CAPF_ACC16]   = 1'b0;
        flags[CAPF_ACC32]   = 1'b0;
        flags[CAPF_ACC64]   = 1'b0;
        flags[CAPF_BNONINC] = 1'b0;
        flags[CAPF_BINC]    = 1'b0;
        flags[CAPF_NOADDR]  = 1'b0;
        case (idx)
            0:       return flags;
            1:       return 8'd0;
            2:       return 8'(aw);
            default: return 8'(DATA_W);
        endcase
    endfunction

endpackage

// File: rtl/csrb_cmd_decoder.sv
module csrb_cmd_decoder
    import csrb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [7:0]               in_data,
    output logic [ADDR_W-1:0]        csr_addr,
    output logic                     csr_re,
    output logic                     csr_we,
    output logic [7:0]               csr_wdata,
    input  logic [7:0]               csr_rdata,
    output logic                     tx_load,
    output logic [2:0]               tx_len,
    output logic [CAP_BYTES*8-1:0]   tx_bytes,
    input  logic                     tx_busy
);

    localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        cmd_state_e          state;
        logic [ADDR_W-1:0]   addr;
        logic [CNT_W-1:0]    cnt;
        logic                is_write;
        logic [7:0]          wdata;
    } dec_reg_t;

    dec_reg_t dec_d, dec_q;

    logic [CAP_BYTES*8-1:0] cap_vec;

    for (genvar g = 0; g < CAP_BYTES; g++) begin : g_cap
        assign cap_vec[g*8 +: 8] = cap_byte(g, ADDR_W);
    end

    always_comb begin
        dec_d    = dec_q;
        in_ready = 1'b0;
        csr_re   = 1'b0;
        csr_we   = 1'b0;
        tx_load  = 1'b0;
        tx_len   = '0;
        tx_bytes = '0;
        case (dec_q.state)
            ST_OPCODE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (in_data == OP_CAPS) begin
                        tx_load     = 1'b1;
                        tx_len      = 3'(CAP_BYTES);
                        tx_bytes    = cap_vec;
                        dec_d.state = ST_DRAIN;
                    end else if (in_data == OP_READ || in_data == OP_WRITE) begin
                        dec_d.is_write = (in_data == OP_WRITE);
                        dec_d.cnt      = '0;
                        dec_d.addr     = '0;
                        dec_d.state    = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    dec_d.addr = ADDR_W'({dec_q.addr, in_data});
                    if (dec_q.cnt == LAST_ADDR) begin
                        dec_d.state = dec_q.is_write ? ST_WDATA : ST_ACCESS;
                    end else begin
                        dec_d.cnt = dec_q.cnt + 1'b1;
                    end
                end
            end
            ST_WDATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    dec_d.wdata = in_data;
                    dec_d.state = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (dec_q.is_write) begin
                    csr_we        = 1'b1;
                    tx_load       = 1'b1;
                    tx_len        = 3'd1;
                    tx_bytes[7:0] = WRITE_ACK;
                    dec_d.state   = ST_DRAIN;
                end else begin
                    csr_re      = 1'b1;
                    dec_d.state = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                tx_load       = 1'b1;
                tx_len        = 3'd1;
                tx_bytes[7:0] = csr_rdata;
                dec_d.state   = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!tx_busy) dec_d.state = ST_OPCODE;
            end
            default: dec_d.state = ST_OPCODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q.state    <= ST_OPCODE;
            dec_q.addr     <= '0;
            dec_q.cnt      <= '0;
            dec_q.is_write <= 1'b0;
            dec_q.wdata    <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign csr_addr  = dec_q.addr;
    assign csr_wdata = dec_q.wdata;

endmodule

// File: rtl/csrb_resp_tx.sv
module csrb_resp_tx
    import csrb_pkg::*;
#(
    parameter int SLOTS = CAP_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [2:0]           len,
    input  logic [SLOTS*8-1:0]   bytes_in,
    output logic                 busy,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [7:0]           out_data
);

    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic [SLOTS*8-1:0] slots;
        logic [IDX_W-1:0]   idx;
        logic [2:0]         left;
    } tx_reg_t;

    tx_reg_t tx_d, tx_q;

    always_comb begin
        tx_d      = tx_q;
        busy      = (tx_q.left != 3'd0);
        out_valid = busy;
        out_data  = tx_q.slots[tx_q.idx*8 +: 8];
        if (out_valid && out_ready) begin
            tx_d.idx  = tx_q.idx + 1'b1;
            tx_d.left = tx_q.left - 3'd1;
        end
        if (load) begin
            tx_d.slots = bytes_in;
            tx_d.idx   = '0;
            tx_d.left  = len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q.slots <= '0;
            tx_q.idx   <= '0;
            tx_q.left  <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

endmodule

// File: rtl/csrb_bridge.sv
module csrb_bridge
    import csrb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic [ADDR_W-1:0] csr_addr,
    output logic              csr_re,
    output logic              csr_we,
    output logic [7:0]        csr_wdata,
    input  logic [7:0]        csr_rdata
);

    logic                   tx_load;
    logic [2:0]             tx_len;
    logic [CAP_BYTES*8-1:0] tx_bytes;
    logic                   tx_busy;

    csrb_cmd_decoder #(.ADDR_W(ADDR_W)) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .csr_addr  (csr_addr),
        .csr_re    (csr_re),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .tx_load   (tx_load),
        .tx_len    (tx_len),
        .tx_bytes  (tx_bytes),
        .tx_busy   (tx_busy)
    );

    csrb_resp_tx #(.SLOTS(CAP_BYTES)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .len       (tx_len),
        .bytes_in  (tx_bytes),
        .busy      (tx_busy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

endmodule

// File: rtl/csrb_bridge_checker.sv
module csrb_bridge_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [7:0]        in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic [ADDR_W-1:0] csr_addr,
    input logic              csr_re,
    input logic              csr_we,
    input logic [7:0]        csr_wdata,
    input logic [7:0]        csr_rdata
);

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_re && csr_we)); // R9

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_re |=> !csr_re); // R9

    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> !csr_we); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_BLOCK_DURING_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R6

    AST_BLOCK_DURING_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_re || csr_we) |-> !in_ready); // R6

    AST_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> (out_valid && out_data == 8'h00)); // R5

    AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csr_re, 2) |-> (out_valid && out_data == $past(csr_rdata, 1))); // R4

    AST_NO_ACCESS_DURING_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(csr_re || csr_we)); // R6

endmodule

bind csrb_bridge csrb_bridge_checker #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/csrb_bridge_tb_top.sv
module csrb_bridge_tb_top;

    localparam int AW = 12;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [1:0]  gap;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 16'h0010, 8'h00, 2'd0, 2'd0},
        '{8'h02, 16'h0010, 8'h5A, 2'd0, 2'd0},
        '{8'h01, 16'h0010, 8'h00, 2'd1, 2'd0},
        '{8'h02, 16'hF0A5, 8'hC3, 2'd2, 2'd1},
        '{8'h01, 16'h00A5, 8'h00, 2'd0, 2'd2},
        '{8'h01, 16'h0FFF, 8'h00, 2'd1, 2'd1},
        '{8'h02, 16'h0123, 8'h99, 2'd0, 2'd2},
        '{8'h01, 16'hE123, 8'h00, 2'd2, 2'd2},
        '{8'h02, 16'h0000, 8'h11, 2'd1, 2'd0},
        '{8'h01, 16'h0000, 8'h00, 2'd0, 2'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [7:0] out_data;
    logic [AW-1:0] csr_addr;
    logic csr_re, csr_we;
    logic [7:0] csr_wdata;
    logic [7:0] csr_rdata;

    always #5 clk = ~clk;

    csrb_bridge #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .csr_addr(csr_addr), .csr_re(csr_re), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    // register file model with one-cycle read latency
    logic [7:0] mem [64];
    logic [7:0] shadow [64];
    logic [7:0] rdata_q = '0;
    int re_cnt = 0;
    int we_cnt = 0;
    logic [AW-1:0] last_addr = '0;
    logic [7:0] last_wdata = '0;

    assign csr_rdata = rdata_q;

    always @(posedge clk) begin
        if (csr_we) begin
            mem[csr_addr[5:0]] <= csr_wdata;
            we_cnt <= we_cnt + 1;
            last_addr <= csr_addr;
            last_wdata <= csr_wdata;
        end
        if (csr_re) begin
            rdata_q <= mem[csr_addr[5:0]];
            re_cnt <= re_cnt + 1;
            last_addr <= csr_addr;
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input int stall);
        repeat (stall) @(negedge clk);
        @(negedge clk);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        b = out_data;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] b;
        int re0, we0;
        for (int i = 0; i < 64; i++) begin
            mem[i]    = 8'hA0 ^ 8'(i * 3);
            shadow[i] = 8'hA0 ^ 8'(i * 3);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(csr_re == 1'b0 && csr_we == 1'b0, "R1 strobes", {csr_re, csr_we}, 0);

        // table-driven reads and writes (R3 R4 R5 R8)
        for (int v = 0; v < NV; v++) begin
            re0 = re_cnt;
            we0 = we_cnt;
            send_byte(VECS[v].op, VECS[v].gap);
            send_byte(VECS[v].addr[15:8], VECS[v].gap);
            send_byte(VECS[v].addr[7:0], VECS[v].gap);
            if (VECS[v].op == 8'h02) begin
                send_byte(VECS[v].wdata, VECS[v].gap);
                recv_byte(b, VECS[v].stall);
                shadow[VECS[v].addr[5:0]] = VECS[v].wdata;
                check(b == 8'h00, "R5 ack byte", b, 0);
                check(we_cnt - we0 == 1 && re_cnt == re0, "R5 one write", we_cnt - we0, 1);
                check(last_wdata == VECS[v].wdata, "R5 wdata", last_wdata, VECS[v].wdata);
            end else begin
                recv_byte(b, VECS[v].stall);
                check(b == shadow[VECS[v].addr[5:0]], "R4 R8 read data", b,
                      shadow[VECS[v].addr[5:0]]);
                check(re_cnt - re0 == 1 && we_cnt == we0, "R4 one read", re_cnt - re0, 1);
            end
            check(last_addr == VECS[v].addr[AW-1:0], "R3 address", last_addr,
                  VECS[v].addr[AW-1:0]);
            repeat (3) @(negedge clk);
            check(out_valid == 1'b0, "R4 R5 single response byte", out_valid, 0);
        end

        // R2: capability query with output stalls
        send_byte(8'h00, 0);
        recv_byte(b, 2);
        check(b == 8'h01, "R2 flags", b, 8'h01);
        recv_byte(b, 0);
        check(b == 8'h00, "R2 burst width", b, 0);
        recv_byte(b, 1);
        check(b == 8'(AW), "R2 addr width", b, AW);
        recv_byte(b, 2);
        check(b == 8'h08, "R2 data width", b, 8);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R2 four bytes only", out_valid, 0);

        // R7: unknown opcodes are dropped
        re0 = re_cnt;
        we0 = we_cnt;
        send_byte(8'h7F, 0);
        send_byte(8'h03, 1);
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R7 no output", out_valid, 0);
        check(re_cnt == re0 && we_cnt == we0, "R7 no access", re_cnt + we_cnt, re0 + we0);
        check(in_ready == 1'b1, "R7 ready for opcode", in_ready, 1);
        send_byte(8'h01, 0);
        send_byte(8'h00, 0);
        send_byte(8'h10, 0);

        // R6: input blocked while the response waits
        repeat (4) @(negedge clk);
        check(in_ready == 1'b0, "R6 in_ready low", in_ready, 0);
        check(out_valid == 1'b1, "R6 response pending", out_valid, 1);
        recv_byte(b, 0);
        check(b == shadow[6'h10], "R7 read after discard", b, shadow[6'h10]);
        repeat (2) @(negedge clk);
        check(in_ready == 1'b1, "R6 in_ready back", in_ready, 1);

        finish_run();
    end

endmodule